// File: doc/BRIEF.md
# Tear-free 16-bit register window for an 8-bit bus

This block sits between an 8-bit processor bus and a 16-bit register, such as a timer compare or capture register. A 16-bit value cannot move in one bus access. The block makes each 16-bit transfer atomic by using a single shared high-byte holding latch.

To read, software first reads the low address. In that same access the block snapshots the register's upper byte into the holding latch, and a later read of the high address returns that snapshot. To write, software first writes the high address, which only loads the holding latch. A write to the low address then presents the holding byte and the new low byte together as one 16-bit write. That write lasts a single cycle.

Writes are honoured only while the register is configured to act as the counter's TOP limit. An input signals this condition.

Top module: `wide_reg_window`

## Requirements
- R1: A read at the low address (`bus_hi`=0, `bus_rd`=1) returns `reg_val[7:0]` on `bus_rdata` combinationally, in the same cycle.
- R2: A low-address read loads `reg_val[15:8]` into the holding latch at the clock edge that ends the access.
- R3: A read at the high address (`bus_hi`=1) returns the holding latch, not the live `reg_val[15:8]`.
- R4: A high-address write with `top_mode`=1 loads `bus_wdata` into the holding latch only, and `reg_we` stays 0.
- R5: A low-address write with `top_mode`=1 drives `reg_we`=1 for that one cycle, with `reg_wdata` = {holding latch, `bus_wdata`}.
- R6: With `top_mode`=0, writes to either address are ignored: `reg_we` stays 0 and the holding latch is unchanged.
- R7: The holding latch is shared by both directions, so a high-address write placed between a low read and a high read changes the value that the high read returns.
- R8: Reset clears the holding latch to zero, so a high read straight after reset returns 0x00.
- R9: `bus_rdata` is 0x00 in any cycle without `bus_rd`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_hi | input | 1 | Byte select: 0 low byte, 1 high byte |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data byte |
| top_mode | input | 1 | 1 when the register acts as counter TOP and may be written |
| reg_val | input | 16 | Current 16-bit register value |
| reg_wdata | output | 16 | 16-bit value to load into the register |
| reg_we | output | 1 | One-cycle load strobe for the register |

## Verification
The bench moves the live value between the low read and the high read. A design that passed the live upper byte through would return the new byte instead of the snapshot. It also writes the high byte with `top_mode` low and then reads it back. A design that did not gate the holding latch would show the stray byte in that read, or pulse `reg_we`. It places a high write between the two halves of a read to confirm that the latch is shared. It reads the high address straight after reset to catch a latch that is not cleared.

// File: rtl/wide_reg_pkg.sv
package wide_reg_pkg;
   typedef enum logic {SEL_LO = 1'b0, SEL_HI = 1'b1} byte_sel_e;
endpackage

// File: rtl/wide_reg_hold.sv
module wide_reg_hold #(
   parameter int BUS_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap_en,
   input  logic [BUS_W-1:0] cap_byte,
   input  logic             ld_en,
   input  logic [BUS_W-1:0] ld_byte,
   output logic [BUS_W-1:0] hold_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)      hold_q <= '0;
      else if (ld_en)  hold_q <= ld_byte;
      else if (cap_en) hold_q <= cap_byte;
   end

   AST_HOLD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_en && !ld_en) |=> hold_q == $past(cap_byte)); // R2
   AST_HOLD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      ld_en |=> hold_q == $past(ld_byte)); // R4
   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!cap_en && !ld_en) |=> $stable(hold_q)); // R6
endmodule

// File: rtl/wide_reg_rdmux.sv
module wide_reg_rdmux #(
   parameter int BUS_W = 8
) (
   input  logic               rd,
   input  logic               hi,
   input  logic [BUS_W-1:0]   lo_byte,
   input  logic [BUS_W-1:0]   hold_byte,
   output logic [BUS_W-1:0]   rdata
);
   import wide_reg_pkg::*;
   always_comb begin
      rdata = '0;
      if (rd) rdata = (byte_sel_e'(hi) == SEL_HI) ? hold_byte : lo_byte;
   end
endmodule

// File: rtl/wide_reg_wrgate.sv
module wide_reg_wrgate #(
   parameter bit GATE_WR = 1'b1
) (
   input  logic wr,
   input  logic hi,
   input  logic mode_ok,
   output logic hi_ld,
   output logic lo_commit
);
   logic allow;
   generate
      if (GATE_WR) begin : g_gated
         assign allow = wr & mode_ok;
      end else begin : g_open
         assign allow = wr;
      end
   endgenerate
   assign hi_ld     = allow & hi;
   assign lo_commit = allow & ~hi;
endmodule

// File: rtl/wide_reg_window.sv
module wide_reg_window #(
   parameter int BUS_W   = 8,
   parameter int REG_W   = 16,
   parameter bit GATE_WR = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_hi,
   input  logic             bus_rd,
   input  logic             bus_wr,
   input  logic [BUS_W-1:0] bus_wdata,
   output logic [BUS_W-1:0] bus_rdata,
   input  logic             top_mode,
   input  logic [REG_W-1:0] reg_val,
   output logic [REG_W-1:0] reg_wdata,
   output logic             reg_we
);
   localparam int HI_LSB = REG_W - BUS_W;

   generate
      if (REG_W != 2 * BUS_W) begin : g_bad_width
         $error("wide_reg_window: REG_W must be twice BUS_W");
      end
      if (BUS_W < 1) begin : g_bad_bus
         $error("wide_reg_window: BUS_W must be positive");
      end
   endgenerate

   logic [BUS_W-1:0] hold_q;
   logic             hi_ld, lo_commit, lo_read;

   assign lo_read = bus_rd & ~bus_hi;

   wide_reg_wrgate #(.GATE_WR(GATE_WR)) u_wrgate (
      .wr(bus_wr), .hi(bus_hi), .mode_ok(top_mode),
      .hi_ld(hi_ld), .lo_commit(lo_commit)
   );

   wide_reg_hold #(.BUS_W(BUS_W)) u_hold (
      .clk(clk), .rst_n(rst_n),
      .cap_en(lo_read), .cap_byte(reg_val[REG_W-1:HI_LSB]),
      .ld_en(hi_ld), .ld_byte(bus_wdata),
      .hold_q(hold_q)
   );

   wide_reg_rdmux #(.BUS_W(BUS_W)) u_rdmux (
      .rd(bus_rd), .hi(bus_hi),
      .lo_byte(reg_val[BUS_W-1:0]), .hold_byte(hold_q),
      .rdata(bus_rdata)
   );

   assign reg_we    = lo_commit;
   assign reg_wdata = {hold_q, bus_wdata};

   AST_WE_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> (top_mode || !GATE_WR)); // R6
   AST_WE_ONLY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> (bus_wr && !bus_hi)); // R4
   AST_COMMIT_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_hi && reg_we == 1'b0 && top_mode) |=> (!(bus_wr && !bus_hi && top_mode) || reg_wdata[REG_W-1:HI_LSB] == $past(bus_wdata))); // R5
   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |-> bus_rdata == '0); // R9
   AST_LO_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !bus_hi) |-> bus_rdata == reg_val[BUS_W-1:0]); // R1
endmodule

// File: tb/wide_reg_window_tb.sv
module wide_reg_window_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_hi = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        top_mode = 1'b0;
   logic [15:0] reg_val = '0;
   logic [15:0] reg_wdata;
   logic        reg_we;

   always #2 clk = ~clk;

   wide_reg_window u_dut (
      .clk(clk), .rst_n(rst_n), .bus_hi(bus_hi), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .top_mode(top_mode),
      .reg_val(reg_val), .reg_wdata(reg_wdata), .reg_we(reg_we)
   );

   // external 16-bit register
   always @(posedge clk) begin
      if (!rst_n) reg_val <= '0;
      else if (reg_we) reg_val <= reg_wdata;
   end

   typedef struct {
      logic [7:0]  rdata;
      logic        we;
      logic [15:0] wdata;
      string       tag;
   } exp_t;

   exp_t exp_q[$];
   int   n_run = 0, n_fail = 0;
   bit   done = 1'b0;

   logic [7:0]  m_hold = '0;
   logic [15:0] m_val  = '0;

   task automatic push(input logic [7:0] rd, input logic we, input logic [15:0] wd, input string tag);
      exp_t e;
      e.rdata = rd; e.we = we; e.wdata = wd; e.tag = tag;
      exp_q.push_back(e);
   endtask

   task automatic set_live(input logic [15:0] v);
      @(negedge clk);
      reg_val = v;
      m_val = v;
   endtask

   task automatic idle(input string tag);
      @(negedge clk);
      bus_rd = 0; bus_wr = 0;
      push(8'h00, 1'b0, 16'h0, tag);
   endtask

   task automatic rd_op(input logic hi, input string tag);
      @(negedge clk);
      bus_rd = 1; bus_wr = 0; bus_hi = hi;
      push(hi ? m_hold : m_val[7:0], 1'b0, 16'h0, tag);
      if (!hi) m_hold = m_val[15:8];
      @(negedge clk);
      bus_rd = 0;
   endtask

   task automatic wr_op(input logic hi, input logic [7:0] d, input string tag);
      logic ok;
      @(negedge clk);
      bus_wr = 1; bus_rd = 0; bus_hi = hi; bus_wdata = d;
      ok = top_mode;
      push(8'h00, ok && !hi, {m_hold, d}, tag);
      if (ok && hi)  m_hold = d;
      if (ok && !hi) m_val = {m_hold, d};
      @(negedge clk);
      bus_wr = 0;
   endtask

   // monitor: compares outputs 1 ns after each falling edge
   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_run++;
            if (bus_rdata !== e.rdata || reg_we !== e.we || (e.we && reg_wdata !== e.wdata)) begin
               n_fail++;
               $display("FAIL %s: rdata=%h we=%b wdata=%h expected rdata=%h we=%b wdata=%h",
                        e.tag, bus_rdata, reg_we, reg_wdata, e.rdata, e.we, e.wdata);
            end
         end
      end
   end

   initial begin
      #200000;
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle("R9 idle after reset");
      rd_op(1'b1, "R8 high read after reset");
      set_live(16'h1234);
      rd_op(1'b0, "R1 low read live");
      set_live(16'h5678);
      rd_op(1'b1, "R2 R3 high read snapshot");
      idle("R9 idle between");
      top_mode = 1'b1;
      wr_op(1'b1, 8'hAB, "R4 high write no strobe");
      rd_op(1'b1, "R4 latch holds written byte");
      wr_op(1'b0, 8'hCD, "R5 low write commits");
      rd_op(1'b0, "R5 low byte after commit");
      rd_op(1'b1, "R5 high byte after commit");
      top_mode = 1'b0;
      wr_op(1'b1, 8'h11, "R6 gated high write");
      rd_op(1'b1, "R6 latch unchanged");
      wr_op(1'b0, 8'h22, "R6 gated low write");
      rd_op(1'b0, "R6 register unchanged");
      top_mode = 1'b1;
      set_live(16'h9A5C);
      rd_op(1'b0, "R7 low read");
      wr_op(1'b1, 8'h77, "R7 intervening high write");
      rd_op(1'b1, "R7 readback corrupted");
      wr_op(1'b0, 8'h01, "R5 commit second pair");
      rd_op(1'b0, "R1 read back committed low");
      rd_op(1'b1, "R3 read back committed high");
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule